// File: doc/BRIEF.md
# Banked Register File with Pointer Access

This block is the byte-wide data store of a small processor core. The address space is split into two banks, and the active bank for a direct access comes from bit 5 of a status byte held inside the block. In each bank the bottom 32 locations hold special registers, and most of them are passed out through a side port to peripheral logic. A stretch of static RAM sits above them in bank 0. Everything else reads as zero.

A direct access combines the bank bit with a 7-bit address. Using direct address 00h turns the access into a pointer access: the 8-bit pointer byte (special register 04h) then serves as the full address, and its top bit picks the bank. The status byte (03h) and the pointer byte (04h) live in the block and appear at the same offset in both banks. Reads are combinational. Writes land on the rising clock edge.

The block has no sequencing of its own. A single decode stage sorts every access into one of six regions: pointer loop, status, pointer, external special register, RAM, or empty. The read mux and the write enables are both driven from that region.

Top module: `bankreg_file`

## Requirements
- R1: After reset, the status byte (03h) and the pointer byte (04h) both read 00h.
- R2: A direct access uses address {status[5], dir_addr}. With status[5]=0, direct addresses 20h–6Fh are RAM: a write stores the byte and a later read returns it.
- R3: With status[5]=1, direct addresses 20h–6Fh are empty. They read 00h, and writes to them do not change the bank-0 RAM at the same offset.
- R4: Offsets 70h–7Fh are empty in both banks. They read 00h and ignore writes.
- R5: Offsets 01h–1Fh, other than 03h and 04h, go to the external port. sfr_addr carries the full 8-bit effective address, with the bank in bit 7. sfr_rd equals rd_en and sfr_wr equals wr_en. sfr_wdata equals wr_data, and rd_data returns sfr_rdata.
- R6: The status and pointer bytes can be written and read at offsets 03h and 04h in either bank. Those accesses do not raise sfr_rd or sfr_wr.
- R7: Direct address 00h accesses the location named by the 8-bit pointer. Pointer bit 7 selects the bank, whatever status[5] holds.
- R8: A pointer access whose pointer has offset 00h (pointer value 00h or 80h) reads 00h and writes nothing. No RAM, status or pointer byte changes, and no external strobe is raised.
- R9: While rd_en is low, rd_data is 00h and sfr_rd is low.
- R10: Stored bytes change only on a clock edge with wr_en high. Presenting an address and data without wr_en leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_addr | input | 7 | Direct address within the active bank |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| sfr_addr | output | 8 | Effective address for external special registers |
| sfr_rd | output | 1 | External special register read strobe |
| sfr_wr | output | 1 | External special register write strobe |
| sfr_wdata | output | 8 | External special register write data |
| sfr_rdata | input | 8 | External special register read data |

## Verification
A wrong bank bit or pointer value shows up on the first read that follows it. It appears either as the wrong RAM byte or as a wrong bank bit in sfr_addr. A decode error in the region boundaries shows up right away on rd_data or on the external strobes for the same address. A write that lands in the wrong place stays hidden until the damaged location is read back. For that reason, each write scenario reads back both the target and the locations that must not change.

// File: rtl/rf_pkg.sv
package rf_pkg;
    typedef enum logic [2:0] {
        RG_LOOP,
        RG_STAT,
        RG_PTR,
        RG_EXT,
        RG_RAM,
        RG_NONE
    } region_e;
endpackage

// File: rtl/rf_decode.sv
module rf_decode
    import rf_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int SFR_SPAN = 32,
    parameter int RAM_LO   = 32,
    parameter int RAM_HI   = 111,
    parameter int STAT_ADR = 3,
    parameter int PTR_ADR  = 4
) (
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic              bank,
    input  logic [ADDR_W:0]   ptr,
    output logic [ADDR_W:0]   eff_addr,
    output region_e           region
);
    localparam logic [ADDR_W-1:0] L_SFR_TOP = ADDR_W'(SFR_SPAN - 1);
    localparam logic [ADDR_W-1:0] L_RAM_LO  = ADDR_W'(RAM_LO);
    localparam logic [ADDR_W-1:0] L_RAM_HI  = ADDR_W'(RAM_HI);
    localparam logic [ADDR_W-1:0] L_STAT    = ADDR_W'(STAT_ADR);
    localparam logic [ADDR_W-1:0] L_PTR     = ADDR_W'(PTR_ADR);
    localparam logic [ADDR_W-1:0] L_IND     = '0;

    logic              ind;
    logic [ADDR_W-1:0] low;

    always_comb begin
        ind      = (dir_addr == L_IND);
        eff_addr = ind ? ptr : {bank, dir_addr};
        low      = eff_addr[ADDR_W-1:0];
        if (low == L_IND)
            region = RG_LOOP;
        else if (low <= L_SFR_TOP) begin
            if (low == L_STAT)
                region = RG_STAT;
            else if (low == L_PTR)
                region = RG_PTR;
            else
                region = RG_EXT;
        end else if (!eff_addr[ADDR_W] && low >= L_RAM_LO && low <= L_RAM_HI)
            region = RG_RAM;
        else
            region = RG_NONE;
    end
endmodule

// File: rtl/rf_gpr_ram.sv
module rf_gpr_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 80,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic          in_range;

    assign in_range = (int'(idx) < DEPTH);

    always_ff @(posedge clk) begin
        if (we && in_range)
            mem[idx] <= wdata;
    end

    assign rdata = in_range ? mem[idx] : '0;
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
    import rf_pkg::*;
#(
    parameter int DW       = 8,
    parameter int ADDR_W   = 7,
    parameter int SFR_SPAN = 32,
    parameter int RAM_LO   = 32,
    parameter int RAM_HI   = 111,
    parameter int STAT_ADR = 3,
    parameter int PTR_ADR  = 4,
    parameter int BANK_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic [ADDR_W:0]   sfr_addr,
    output logic              sfr_rd,
    output logic              sfr_wr,
    output logic [DW-1:0]     sfr_wdata,
    input  logic [DW-1:0]     sfr_rdata
);
    localparam int PTR_W     = ADDR_W + 1;
    localparam int RAM_DEPTH = RAM_HI - RAM_LO + 1;
    localparam int IDX_W     = $clog2(RAM_DEPTH);
    localparam logic [ADDR_W-1:0] L_RAM_LO = ADDR_W'(RAM_LO);

    logic [DW-1:0]     status_q;
    logic [PTR_W-1:0]  fsr_q;
    logic [ADDR_W:0]   eff_addr;
    region_e           region;
    logic [ADDR_W-1:0] ram_off;
    logic [IDX_W-1:0]  ram_idx;
    logic [DW-1:0]     ram_rdata;
    logic              ram_we;
    logic [DW-1:0]     rd_mux;

    rf_decode #(
        .ADDR_W  (ADDR_W),
        .SFR_SPAN(SFR_SPAN),
        .RAM_LO  (RAM_LO),
        .RAM_HI  (RAM_HI),
        .STAT_ADR(STAT_ADR),
        .PTR_ADR (PTR_ADR)
    ) u_dec (
        .dir_addr(dir_addr),
        .bank    (status_q[BANK_BIT]),
        .ptr     (fsr_q),
        .eff_addr(eff_addr),
        .region  (region)
    );

    assign ram_off = eff_addr[ADDR_W-1:0] - L_RAM_LO;
    assign ram_idx = ram_off[IDX_W-1:0];
    assign ram_we  = wr_en && (region == RG_RAM);

    rf_gpr_ram #(
        .DW   (DW),
        .DEPTH(RAM_DEPTH),
        .IDX_W(IDX_W)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .idx  (ram_idx),
        .wdata(wr_data),
        .rdata(ram_rdata)
    );

    // Core-held special registers, visible at the same offset in both banks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            fsr_q    <= '0;
        end else if (wr_en) begin
            if (region == RG_STAT)
                status_q <= wr_data;
            if (region == RG_PTR)
                fsr_q <= wr_data[PTR_W-1:0];
        end
    end

    always_comb begin
        unique case (region)
            RG_STAT: rd_mux = status_q;
            RG_PTR:  rd_mux = DW'(fsr_q);
            RG_EXT:  rd_mux = sfr_rdata;
            RG_RAM:  rd_mux = ram_rdata;
            default: rd_mux = '0;
        endcase
    end

    assign rd_data   = rd_en ? rd_mux : '0;
    assign sfr_addr  = eff_addr;
    assign sfr_rd    = rd_en && (region == RG_EXT);
    assign sfr_wr    = wr_en && (region == RG_EXT);
    assign sfr_wdata = wr_data;
endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk #(
    parameter int DW     = 8,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] dir_addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DW-1:0]     rd_data,
    input logic              sfr_rd,
    input logic              sfr_wr,
    input logic [DW-1:0]     status_q,
    input logic [ADDR_W:0]   fsr_q
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status_q == '0 && fsr_q == '0)); // R1

    AST_EXT_WR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr |-> wr_en); // R5

    AST_EMPTY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_addr >= 7'h70) |-> (!sfr_rd && !sfr_wr && rd_data == '0)); // R4

    AST_PTR_LOOP_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_addr == '0 && fsr_q[ADDR_W-1:0] == '0) |-> (!sfr_rd && !sfr_wr && rd_data == '0)); // R8

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0 && !sfr_rd)); // R9

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(status_q)); // R10

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(fsr_q)); // R10
endmodule

bind bankreg_file bankreg_file_chk u_chk (.*);

// File: tb/bankreg_file_tb.sv
module bankreg_file_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] dir_addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] sfr_addr;
    logic       sfr_rd;
    logic       sfr_wr;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // External register model: data derived from address
    assign sfr_rdata = sfr_addr ^ 8'h5A;

    bankreg_file u_dut (
        .clk(clk), .rst_n(rst_n), .dir_addr(dir_addr), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic do_wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        dir_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        dir_addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        do_rd(7'h03, v); check("R1 status", v, 8'h00);
        do_rd(7'h04, v); check("R1 pointer", v, 8'h00);
    endtask

    task automatic t_ram_bank0;
        logic [7:0] v;
        do_wr(7'h20, 8'h11);
        do_wr(7'h6F, 8'h22);
        do_wr(7'h45, 8'h33);
        do_rd(7'h20, v); check("R2 ram 20h", v, 8'h11);
        do_rd(7'h6F, v); check("R2 ram 6Fh", v, 8'h22);
        do_rd(7'h45, v); check("R2 ram 45h", v, 8'h33);
        // R10: address and data presented without write strobe
        @(negedge clk);
        dir_addr = 7'h45; wr_data = 8'hEE;
        @(negedge clk);
        do_rd(7'h45, v); check("R10 no strobe", v, 8'h33);
    endtask

    task automatic t_bank1;
        logic [7:0] v;
        do_wr(7'h25, 8'h5C);
        do_wr(7'h03, 8'h20);
        do_rd(7'h03, v); check("R6 status bank1", v, 8'h20);
        do_wr(7'h25, 8'hAA);
        do_rd(7'h25, v); check("R3 bank1 empty read", v, 8'h00);
        do_wr(7'h04, 8'h3C);
        do_rd(7'h04, v); check("R6 pointer via bank1", v, 8'h3C);
        do_wr(7'h03, 8'h00);
        do_rd(7'h25, v); check("R3 bank0 intact", v, 8'h5C);
        do_rd(7'h04, v); check("R6 pointer mirrored", v, 8'h3C);
    endtask

    task automatic t_empty_top;
        logic [7:0] v;
        do_wr(7'h70, 8'h99);
        do_wr(7'h7F, 8'h98);
        do_rd(7'h70, v); check("R4 70h", v, 8'h00);
        do_rd(7'h7F, v); check("R4 7Fh", v, 8'h00);
        do_wr(7'h03, 8'h20);
        do_rd(7'h7A, v); check("R4 bank1 7Ah", v, 8'h00);
        do_wr(7'h03, 8'h00);
        do_rd(7'h6F, v); check("R4 neighbour intact", v, 8'h22);
    endtask

    task automatic t_ext;
        @(negedge clk);
        dir_addr = 7'h10; rd_en = 1'b1;
        #1;
        check("R5 addr", sfr_addr, 8'h10);
        check("R5 rd strobe", {7'd0, sfr_rd}, 8'h01);
        check("R5 rdata", rd_data, 8'h10 ^ 8'h5A);
        rd_en = 1'b0;
        dir_addr = 7'h1F; wr_en = 1'b1; wr_data = 8'hC3;
        #1;
        check("R5 wr strobe", {7'd0, sfr_wr}, 8'h01);
        check("R5 wdata", sfr_wdata, 8'hC3);
        check("R9 idle rd strobe", {7'd0, sfr_rd}, 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        do_wr(7'h03, 8'h20);
        @(negedge clk);
        dir_addr = 7'h05; rd_en = 1'b1;
        #1;
        check("R5 bank1 addr", sfr_addr, 8'h85);
        check("R5 bank1 rdata", rd_data, 8'h85 ^ 8'h5A);
        dir_addr = 7'h03;
        #1;
        check("R6 status not external", {7'd0, sfr_rd}, 8'h00);
        rd_en = 1'b0;
        @(negedge clk);
        dir_addr = 7'h04; wr_en = 1'b1; wr_data = 8'h3C;
        #1;
        check("R6 pointer not external", {7'd0, sfr_wr}, 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        do_wr(7'h03, 8'h00);
    endtask

    task automatic t_indirect;
        logic [7:0] v;
        do_wr(7'h04, 8'h30);
        do_wr(7'h00, 8'h77);
        do_rd(7'h30, v); check("R7 write via pointer", v, 8'h77);
        do_rd(7'h00, v); check("R7 read via pointer", v, 8'h77);
        do_wr(7'h04, 8'h83);
        do_rd(7'h00, v); check("R7 bank1 status via pointer", v, 8'h00);
        do_wr(7'h04, 8'hB0);
        do_rd(7'h00, v); check("R7 pointer bank1 RAM empty", v, 8'h00);
        do_wr(7'h04, 8'h8A);
        @(negedge clk);
        dir_addr = 7'h00; rd_en = 1'b1;
        #1;
        check("R7 pointer ext addr", sfr_addr, 8'h8A);
        check("R7 pointer ext rdata", rd_data, 8'h8A ^ 8'h5A);
        rd_en = 1'b0;
    endtask

    task automatic t_loop;
        logic [7:0] v;
        do_wr(7'h04, 8'h00);
        @(negedge clk);
        dir_addr = 7'h00; wr_en = 1'b1; wr_data = 8'h44;
        #1;
        check("R8 no ext write", {7'd0, sfr_wr}, 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        do_rd(7'h00, v); check("R8 loop reads zero", v, 8'h00);
        do_rd(7'h04, v); check("R8 pointer unchanged", v, 8'h00);
        do_rd(7'h03, v); check("R8 status unchanged", v, 8'h00);
        do_wr(7'h04, 8'h80);
        do_wr(7'h00, 8'h55);
        do_rd(7'h00, v); check("R8 loop 80h reads zero", v, 8'h00);
        do_rd(7'h04, v); check("R8 pointer 80h unchanged", v, 8'h80);
        do_rd(7'h30, v); check("R8 ram unchanged", v, 8'h77);
    endtask

    task automatic t_idle;
        @(negedge clk);
        dir_addr = 7'h30; rd_en = 1'b0;
        #1;
        check("R9 idle read zero", rd_data, 8'h00);
        dir_addr = 7'h10;
        #1;
        check("R9 idle no ext read", {7'd0, sfr_rd}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ram_bank0();
        t_bank1();
        t_empty_top();
        t_ext();
        t_indirect();
        t_loop();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule